// File: doc/BRIEF.md
# Four-Sample Moving-Average Threshold Alarm

This block watches a 32-bit unsigned temperature reading and raises a one-bit alarm when the mean of the four most recent readings reaches a 32-bit unsigned threshold. A controller visits a sampling state once every `GAP_CYCLES` clock cycles. On each visit it pushes the current reading into a four-deep history of registers. In the same cycle it loads an average register with the truncated mean of the history as it stood before the push. The controller then moves to an alarm-on or an alarm-off waiting state, chosen by comparing that new mean against the threshold. It holds that state until the interval timer runs out.

A clear input takes priority over everything else. While clear is high the block sits in an idle clear state. In that state the alarm is low and the history is never written. When clear drops, the block passes through an initialisation state that zeroes the history and the average, and then sampling starts again. Until four readings have been taken after initialisation, the zeroed history entries count in the mean.

Top module: `tavg_alarm`

## Requirements
- R1: While the synchronous reset is high, the block goes to its initialisation state on the next clock edge with the alarm at 0. The cycle after reset is released, the alarm is still 0.
- R2: The initialisation state clears all four history registers and the average register and holds the alarm at 0. If clear is low, the next state is the sampling state.
- R3: In a sampling cycle with clear low, the current reading is written into history slot 0, and slots 0, 1 and 2 move into slots 1, 2 and 3.
- R4: The value computed in a sampling cycle is the sum of the four history slots before the push, formed without overflow (34 bits), shifted right by two. The fraction is discarded. Four readings of 0xFFFFFFFF therefore average to 0xFFFFFFFF.
- R5: The alarm is 1 only in the alarm-on state. The state after a sampling cycle is alarm-on when the new mean is greater than or equal to the threshold present in that cycle, and alarm-off otherwise. An equal value counts as an alarm.
- R6: Sampling cycles occur exactly `GAP_CYCLES` cycles apart (default 4, minimum 2). In the `GAP_CYCLES-1` cycles between them, the alarm keeps its value even if the reading or the threshold changes.
- R7: When clear is 1 at a clock edge, the next state is the clear state, from any state, and the alarm is 0 from then on. No history register changes while clear is high. When clear returns to 0, the block spends one cycle in initialisation and then samples.
- R8: After initialisation, the first four means include the zeroed history slots. With a constant reading v, the means are 0, v/4, 2v/4, 3v/4, and then v from the fifth sampling cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| temp_i | input | 32 | Current temperature reading, unsigned |
| thresh_i | input | 32 | Warning threshold, unsigned |
| clear_i | input | 1 | Stops sampling and forces the alarm low while high |
| alarm_o | output | 1 | High while the latest mean is at or above the threshold |

## Verification
The embedded properties check the following on every cycle:
- clear sends the controller to its clear state on the next edge;
- initialisation is followed by sampling;
- the waiting states hold until the timer expires;
- the timer reloads after each sample;
- the history shifts one slot per sample and stays frozen otherwise;
- an alarm rising edge is backed by a stored mean at or above the previous threshold.

The exact sampling cadence, the truncating arithmetic at full scale, the equality case and the warm-up with zeroed slots can only be seen at the alarm pin. The bench shows them by comparing the alarm against its own cycle model in directed and random scenarios.

// File: rtl/tavg_pkg.sv
package tavg_pkg;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_CLEAR   = 3'd1,
        ST_SAMPLE  = 3'd2,
        ST_ALM_ON  = 3'd3,
        ST_ALM_OFF = 3'd4
    } ctl_state_e;

endpackage

// File: rtl/tavg_history.sv
module tavg_history #(
    parameter int W    = 32,
    parameter int TAPS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         zero_i,
    input  logic         shift_i,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] avg_next_o,
    output logic [W-1:0] avg_o
);
    localparam int SHIFT = $clog2(TAPS);
    localparam int SW    = W + SHIFT;

    typedef struct packed {
        logic [TAPS-1:0][W-1:0] tap;
        logic [W-1:0]           avg;
    } hist_t;

    hist_t         h_d, h_q;
    logic [SW-1:0] sum;

    always_comb begin
        sum = '0;
        for (int i = 0; i < TAPS; i++) begin
            sum = sum + SW'(h_q.tap[i]);
        end
        avg_next_o = W'(sum >> SHIFT);

        h_d = h_q;
        if (zero_i) begin
            h_d = '0;
        end else if (shift_i) begin
            h_d.tap[0] = sample_i;
            for (int i = 1; i < TAPS; i++) begin
                h_d.tap[i] = h_q.tap[i-1];
            end
            h_d.avg = avg_next_o;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) h_q <= '0;
        else     h_q <= h_d;
    end

    assign avg_o = h_q.avg;

    // R2: zeroing clears all history and the average
    a_r2_zeroed: assert property (@(posedge clk) disable iff (rst)
        zero_i |=> (h_q == '0));

    // R3: the new reading enters slot 0
    a_r3_enter: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !zero_i) |=> (h_q.tap[0] == $past(sample_i)));

    // R3: each slot takes its neighbour's old value
    for (genvar g = 1; g < TAPS; g++) begin : g_shift_chk
        a_r3_shift: assert property (@(posedge clk) disable iff (rst)
            (shift_i && !zero_i) |=> (h_q.tap[g] == $past(h_q.tap[g-1])));
    end

    // R7: without a sample or zero, nothing in the history moves
    a_r7_hold_hist: assert property (@(posedge clk) disable iff (rst)
        (!shift_i && !zero_i) |=> $stable(h_q));

endmodule

// File: rtl/tavg_gap_timer.sv
module tavg_gap_timer #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic done_o
);
    localparam int CW = (GAP > 2) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(GAP - 2);

    logic [CW-1:0] cnt_d, cnt_q;

    initial begin
        assert (GAP >= 2) else $error("GAP must be at least 2");
    end

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)           cnt_d = RELOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

    // R6: every sample restarts the interval
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == RELOAD));

endmodule

// File: rtl/tavg_ctrl.sv
module tavg_ctrl
    import tavg_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         done_i,
    input  logic [W-1:0] avg_next_i,
    input  logic [W-1:0] thresh_i,
    output logic         zero_o,
    output logic         shift_o,
    output logic         load_o,
    output logic         alarm_o
);
    typedef struct packed {
        ctl_state_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic at_or_above;

    always_comb begin
        at_or_above = (avg_next_i >= thresh_i);
        ctl_d   = ctl_q;
        zero_o  = 1'b0;
        shift_o = 1'b0;
        load_o  = 1'b0;
        unique case (ctl_q.st)
            ST_INIT: begin
                zero_o   = 1'b1;
                ctl_d.st = clear_i ? ST_CLEAR : ST_SAMPLE;
            end
            ST_CLEAR: begin
                ctl_d.st = clear_i ? ST_CLEAR : ST_INIT;
            end
            ST_SAMPLE: begin
                if (clear_i) begin
                    ctl_d.st = ST_CLEAR;
                end else begin
                    shift_o  = 1'b1;
                    load_o   = 1'b1;
                    ctl_d.st = at_or_above ? ST_ALM_ON : ST_ALM_OFF;
                end
            end
            ST_ALM_ON, ST_ALM_OFF: begin
                if (clear_i)     ctl_d.st = ST_CLEAR;
                else if (done_i) ctl_d.st = ST_SAMPLE;
            end
            default: ctl_d.st = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q.st <= ST_INIT;
        else     ctl_q <= ctl_d;
    end

    assign alarm_o = (ctl_q.st == ST_ALM_ON);

    // R7: clear wins from any state
    a_r7_clear_enter: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (ctl_q.st == ST_CLEAR && !alarm_o));

    // R2: initialisation leads to sampling
    a_r2_init_next: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_INIT && !clear_i) |=> (ctl_q.st == ST_SAMPLE));

    // R5: the alarm after a sample follows the comparison
    a_r5_decision: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_SAMPLE && !clear_i) |=> (alarm_o == $past(at_or_above)));

    // R6: waiting states hold until the timer expires
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        ((ctl_q.st == ST_ALM_ON || ctl_q.st == ST_ALM_OFF) && !clear_i && !done_i)
            |=> $stable(ctl_q.st));

endmodule

// File: rtl/tavg_alarm.sv
module tavg_alarm #(
    parameter int W          = 32,
    parameter int TAPS       = 4,
    parameter int GAP_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] temp_i,
    input  logic [W-1:0] thresh_i,
    input  logic         clear_i,
    output logic         alarm_o
);
    logic         zero, shift, load, done;
    logic [W-1:0] avg_next, avg_q;

    tavg_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear_i),
        .done_i     (done),
        .avg_next_i (avg_next),
        .thresh_i   (thresh_i),
        .zero_o     (zero),
        .shift_o    (shift),
        .load_o     (load),
        .alarm_o    (alarm_o)
    );

    tavg_history #(.W(W), .TAPS(TAPS)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .zero_i     (zero),
        .shift_i    (shift),
        .sample_i   (temp_i),
        .avg_next_o (avg_next),
        .avg_o      (avg_q)
    );

    tavg_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .done_o (done)
    );

    // R5: a rising alarm is backed by the stored mean
    a_r5_rise_backed: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_o) |-> (avg_q >= $past(thresh_i)));

    // R1: reset leaves the alarm low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !alarm_o);

endmodule

// File: tb/sim_tavg_alarm.sv
module sim_tavg_alarm;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] temp = '0;
    logic [31:0] thr  = '0;
    logic        clear = 1'b0;
    logic        alarm;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model: 0 init, 1 clear, 2 sample, 3 on, 4 off
    int          m_st   = 0;
    int          m_left = 0;
    logic [31:0] m_h [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    tavg_alarm #(.W(32), .TAPS(4), .GAP_CYCLES(GAP)) u0 (
        .clk      (clk),
        .rst      (rst),
        .temp_i   (temp),
        .thresh_i (thr),
        .clear_i  (clear),
        .alarm_o  (alarm)
    );

    function automatic logic [31:0] mean4(input logic [31:0] a, b, c, d);
        logic [33:0] s;
        s = {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d};
        return s[33:2];
    endfunction

    task automatic model_edge(input logic r, input logic [31:0] ct,
                              input logic [31:0] th, input logic cl);
        logic [31:0] a;
        if (r) begin
            m_st = 0;
            for (int i = 0; i < 4; i++) m_h[i] = '0;
            return;
        end
        case (m_st)
            0: begin
                for (int i = 0; i < 4; i++) m_h[i] = '0;
                m_st = cl ? 1 : 2;
            end
            1: m_st = cl ? 1 : 0;
            2: begin
                if (cl) m_st = 1;
                else begin
                    a = mean4(m_h[0], m_h[1], m_h[2], m_h[3]);
                    m_h[3] = m_h[2]; m_h[2] = m_h[1]; m_h[1] = m_h[0]; m_h[0] = ct;
                    m_left = GAP - 1;
                    m_st = (a >= th) ? 3 : 4;
                end
            end
            default: begin
                if (cl) m_st = 1;
                else begin
                    m_left--;
                    if (m_left == 0) m_st = 2;
                end
            end
        endcase
    endtask

    // one cycle: check at negedge, drive, advance model, pass the edge
    task automatic cyc(input logic r, input logic [31:0] ct, input logic [31:0] th,
                       input logic cl, input string tag);
        logic exp;
        exp = (m_st == 3);
        n_checks++;
        if (alarm !== exp) begin
            n_fail++;
            $display("FAIL %s: alarm=%0b expected=%0b at %0t", tag, alarm, exp, $time);
        end
        rst = r; temp = ct; thr = th; clear = cl;
        model_edge(r, ct, th, cl);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hold(input logic [31:0] ct, input logic [31:0] th, input logic cl,
                        input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, ct, th, cl, tag);
    endtask

    task automatic restart(input string tag);
        hold(32'd0, 32'd0, 1'b1, 2, tag);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(1'b1, 32'd500, 32'd0, 1'b0, "R1");
        cyc(1'b0, 32'd0, 32'd0, 1'b0, "R1");

        // R2, R3, R8: warm-up with constant reading, alarm at 4th sample
        restart("R7");
        hold(32'd100, 32'd75, 1'b0, 7 * GAP, "R8");
        restart("R2");
        hold(32'd100, 32'd100, 1'b0, 7 * GAP, "R3");

        // R4: truncation 1,1,1,2 -> mean 1
        restart("R4");
        cyc(1'b0, 32'd0, 32'd2, 1'b0, "R2");
        hold(32'd1, 32'd2, 1'b0, 3 * GAP, "R4");
        hold(32'd2, 32'd2, 1'b0, GAP, "R4");
        hold(32'd9, 32'd2, 1'b0, GAP, "R4");
        hold(32'd9, 32'd1, 1'b0, 2 * GAP, "R4");

        // R4: full-scale readings must not wrap
        restart("R4");
        hold(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 7 * GAP, "R4");
        hold(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 2 * GAP, "R4");

        // R5: equality counts as alarm, one above does not
        restart("R5");
        hold(32'd40, 32'd40, 1'b0, 7 * GAP, "R5");
        hold(32'd40, 32'd41, 1'b0, 2 * GAP, "R5");

        // R6: threshold change between samples has no effect until next sample
        restart("R6");
        hold(32'd50, 32'd10, 1'b0, 6 * GAP, "R6");
        for (int k = 0; k < 3 * GAP; k++)
            cyc(1'b0, 32'd50, (k % 2) ? 32'd10 : 32'd999, 1'b0, "R6");

        // R7: clear in the middle of an alarm, history frozen
        hold(32'd50, 32'd10, 1'b0, GAP, "R7");
        hold(32'd7, 32'd10, 1'b1, 5, "R7");
        hold(32'd50, 32'd10, 1'b0, 7 * GAP, "R7");

        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] ct, th;
            logic        cl;
            ct = $urandom_range(0, 400);
            th = ($urandom_range(0, 9) == 0) ? $urandom : $urandom_range(0, 400);
            cl = ($urandom_range(0, 49) == 0);
            cyc(1'b0, ct, th, cl, "R5");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule